// File: doc/BRIEF.md
# Five-State Snooping Coherence Line Controller

This block holds the coherence state of one line in one write-back cache attached to a shared snooping bus. It takes the local processor's read, write and eviction requests, along with the transactions it observes from other caches. From these it computes the line's next state and issues the bus request that the transition needs. The five states are Invalid, Shared, Exclusive, Owned and Modified. In the Owned state a dirty line may coexist with clean Shared copies elsewhere, and every local write to it broadcasts the new value on the bus, where a four-state protocol would invalidate the other copies.

The bus is atomic: a request and all of its replies finish before the next request is granted, so the controller needs no transient states. A snooped transaction always takes precedence over the local request in the same cycle. During a snoop the controller answers the same cycle with a "holds the line" signal and a "supplies the data" signal. The input `own_write_keeps_owned` selects how a local write to an Owned line is handled. When it is 1 the line stays Owned and broadcasts. When it is 0 the line moves to Modified and invalidates the other copies.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset `line_state` is Invalid and `bus_req_valid` is 0. The state encoding is Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A local read to an Invalid line issues a bus read. The line becomes Exclusive when `others_share` is 0 and Shared when it is 1. A local read in any other state issues no request and leaves the state unchanged.
- R3: A local write while `others_share` is 0 has these effects:
  - Invalid goes to Modified with a read-for-ownership.
  - Shared goes to Modified with an invalidate.
  - Exclusive goes to Modified with no request.
  - Modified stays Modified with no request.
- R4: A local write to an Invalid or Shared line while `others_share` is 1 moves the line to Owned and issues a value broadcast.
- R5: A local write to an Owned line stays in Owned with a broadcast when `own_write_keeps_owned` is 1. When it is 0, the line moves to Modified with an invalidate. Exclusive never moves to Owned.
- R6: A snooped read has these effects:
  - Modified moves to Owned.
  - Exclusive moves to Shared.
  - Owned and Shared stay unchanged.
  - `supply_data` is 1 in that cycle when the line is Modified or Owned.
- R7: A snooped value broadcast moves an Owned, Modified or Exclusive line to Shared. A Shared or Invalid line keeps its state.
- R8: A snooped read-for-ownership or invalidate moves Shared, Exclusive and Modified lines to Invalid. It moves Owned to Shared and never to Invalid. A Modified or Owned line raises `supply_data` on a read-for-ownership.
- R9: Eviction has these effects:
  - A Modified or Owned line goes to Invalid with a writeback.
  - A Shared or Exclusive line goes to Invalid with no request.
  - Local requests are prioritised eviction, then write, then read.
- R10: In a cycle with `snoop_valid` high, local requests are ignored. The next state follows only the snoop, and no bus request is issued.
- R11: `shared_out` is 1 exactly when `snoop_valid` is 1 and the line is not Invalid. It is combinational in the same cycle.
- R12: A bus request is registered and appears for exactly one cycle, after the clock edge that accepts the causing request. The encodings are read=0, read-for-ownership=1, invalidate=2, broadcast=3, writeback=4, and the same codes are used on `snoop_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Local read request |
| cpu_wr | input | 1 | Local write request |
| cpu_evict | input | 1 | Local eviction of the line |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | OP_W | Code of the snooped transaction |
| others_share | input | 1 | Another cache holds the line (bus response to local requests) |
| own_write_keeps_owned | input | 1 | Write in Owned: 1 stay Owned, 0 go to Modified |
| line_state | output | ST_W | Current coherence state |
| bus_req_valid | output | 1 | Bus request issued this cycle |
| bus_req_op | output | OP_W | Code of the issued request |
| shared_out | output | 1 | This cache holds the snooped line |
| supply_data | output | 1 | This cache provides dirty data for the snooped read |

## Verification
The bench builds the block with the default widths `ST_W`=3 and `OP_W`=3, which are the narrowest the state and operation codes allow. With these widths every encoded value, including the unused operation codes, is reachable through a port. The random phase therefore walks all five states under every mix of snoop and local request, `others_share` and the Owned-write selector. Directed sequences pin down the Owned-entry paths, both Owned-write variants, and the snoop-over-local priority.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_O = 3'd3,
      ST_M = 3'd4
   } line_st_e;

   typedef enum logic [2:0] {
      OP_RD    = 3'd0,
      OP_RFO   = 3'd1,
      OP_INV   = 3'd2,
      OP_BCAST = 3'd3,
      OP_WB    = 3'd4
   } bus_op_e;

   typedef struct packed {
      logic    valid;
      bus_op_e op;
   } bus_req_t;

   localparam int STATE_BITS = $bits(line_st_e);
   localparam int OP_BITS    = $bits(bus_op_e);
endpackage

// File: rtl/moesi_next_state.sv
module moesi_next_state
   import moesi_pkg::*;
(
   input  line_st_e st,
   input  logic     rd,
   input  logic     wr,
   input  logic     ev,
   input  logic     snv,
   input  bus_op_e  sop,
   input  logic     sh_in,
   input  logic     keep_owned,
   output line_st_e nst,
   output bus_req_t req
);
   always_comb begin
      nst       = st;
      req.valid = 1'b0;
      req.op    = OP_RD;
      if (snv) begin
         case (sop)
            OP_RD: begin
               if (st == ST_M) nst = ST_O;
               else if (st == ST_E) nst = ST_S;
            end
            OP_RFO, OP_INV: begin
               if (st == ST_S || st == ST_E || st == ST_M) nst = ST_I;
               else if (st == ST_O) nst = ST_S;
            end
            OP_BCAST: begin
               if (st != ST_I) nst = ST_S;
            end
            default: ;
         endcase
      end else if (ev) begin
         nst = ST_I;
         if (st == ST_M || st == ST_O) begin
            req.valid = 1'b1;
            req.op    = OP_WB;
         end
      end else if (wr) begin
         case (st)
            ST_I, ST_S: begin
               req.valid = 1'b1;
               if (sh_in) begin
                  nst    = ST_O;
                  req.op = OP_BCAST;
               end else begin
                  nst    = ST_M;
                  req.op = (st == ST_I) ? OP_RFO : OP_INV;
               end
            end
            ST_O: begin
               req.valid = 1'b1;
               if (keep_owned) begin
                  nst    = ST_O;
                  req.op = OP_BCAST;
               end else begin
                  nst    = ST_M;
                  req.op = OP_INV;
               end
            end
            default: nst = ST_M;
         endcase
      end else if (rd) begin
         if (st == ST_I) begin
            nst       = sh_in ? ST_S : ST_E;
            req.valid = 1'b1;
            req.op    = OP_RD;
         end
      end
   end
endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
   import moesi_pkg::*;
(
   input  line_st_e st,
   input  logic     snv,
   input  bus_op_e  sop,
   output logic     holds,
   output logic     supplies
);
   logic dirty;
   logic wants_data;

   assign dirty      = (st == ST_M) || (st == ST_O);
   assign wants_data = (sop == OP_RD) || (sop == OP_RFO);
   assign holds      = snv && (st != ST_I);
   assign supplies   = snv && wants_data && dirty;
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
   import moesi_pkg::*;
#(
   parameter int ST_W = 3,
   parameter int OP_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_rd,
   input  logic            cpu_wr,
   input  logic            cpu_evict,
   input  logic            snoop_valid,
   input  logic [OP_W-1:0] snoop_op,
   input  logic            others_share,
   input  logic            own_write_keeps_owned,
   output logic [ST_W-1:0] line_state,
   output logic            bus_req_valid,
   output logic [OP_W-1:0] bus_req_op,
   output logic            shared_out,
   output logic            supply_data
);
   localparam int OP_PAD = OP_W - OP_BITS;

   initial begin
      if (ST_W < STATE_BITS) $fatal(1, "ST_W too narrow for the state code");
      if (OP_W < OP_BITS)    $fatal(1, "OP_W too narrow for the operation code");
   end

   line_st_e st_q, st_d;
   bus_req_t req_d, req_q;
   bus_op_e  sop;
   logic     known_op;

   generate
      if (OP_PAD > 0) begin : g_wide_op
         assign known_op = (snoop_op[OP_W-1:OP_BITS] == '0);
      end else begin : g_exact_op
         assign known_op = 1'b1;
      end
   endgenerate

   assign sop = known_op ? bus_op_e'(snoop_op[OP_BITS-1:0]) : bus_op_e'(3'd7);

   moesi_next_state u_next (
      .st         (st_q),
      .rd         (cpu_rd),
      .wr         (cpu_wr),
      .ev         (cpu_evict),
      .snv        (snoop_valid),
      .sop        (sop),
      .sh_in      (others_share),
      .keep_owned (own_write_keeps_owned),
      .nst        (st_d),
      .req        (req_d)
   );

   moesi_snoop_resp u_resp (
      .st       (st_q),
      .snv      (snoop_valid),
      .sop      (sop),
      .holds    (shared_out),
      .supplies (supply_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_I;
         req_q <= '0;
      end else begin
         st_q  <= st_d;
         req_q <= req_d;
      end
   end

   assign line_state    = ST_W'(st_q);
   assign bus_req_valid = req_q.valid;
   assign bus_req_op    = OP_W'(req_q.op);

   // R5
   excl_not_to_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_E) |=> (st_q != ST_O));

   // R8
   owned_leaves_only_by_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_O && !(cpu_evict && !snoop_valid)) |=> (st_q != ST_I && st_q != ST_E));

   // R6
   snoop_rd_mod_to_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && sop == OP_RD && st_q == ST_M) |=> (st_q == ST_O));

   // R9
   writeback_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == OP_W'(OP_WB)) |-> ($past(st_q) == ST_M || $past(st_q) == ST_O));

   // R10
   snoop_blocks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |=> !bus_req_valid);

   // R11
   shared_needs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shared_out |-> (st_q != ST_I));
endmodule

// File: tb/moesi_line_ctrl_test.sv
module moesi_line_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_rd = 0, cpu_wr = 0, cpu_evict = 0, snoop_valid = 0;
   logic [2:0] snoop_op = 0;
   logic       others_share = 0, own_write_keeps_owned = 1;
   logic [2:0] line_state;
   logic       bus_req_valid;
   logic [2:0] bus_req_op;
   logic       shared_out, supply_data;

   int checks = 0;
   int errors = 0;
   logic [2:0] ms = 3'd0;   // bench model state

   localparam logic [2:0] I = 0, S = 1, E = 2, O = 3, M = 4;
   localparam logic [2:0] RD = 0, RFO = 1, INV = 2, BC = 3, WB = 4;

   always #4 clk = ~clk;

   moesi_line_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_evict(cpu_evict), .snoop_valid(snoop_valid), .snoop_op(snoop_op),
      .others_share(others_share), .own_write_keeps_owned(own_write_keeps_owned),
      .line_state(line_state), .bus_req_valid(bus_req_valid),
      .bus_req_op(bus_req_op), .shared_out(shared_out), .supply_data(supply_data)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [2:0] st, input logic rd, input logic wr,
         input logic ev, input logic snv, input logic [2:0] sop, input logic sh,
         input logic keep, output logic [2:0] nst, output logic v,
         output logic [2:0] op, output string tag);
      nst = st; v = 0; op = 0; tag = "R2";
      if (snv) begin
         tag = (rd || wr || ev) ? "R10" : (sop == RD) ? "R6" : (sop == BC) ? "R7" : "R8";
         if (sop == RD) begin
            if (st == M) nst = O; else if (st == E) nst = S;
         end else if (sop == RFO || sop == INV) begin
            if (st == O) nst = S; else nst = I;
         end else if (sop == BC) begin
            if (st != I) nst = S;
         end
      end else if (ev) begin
         tag = "R9"; nst = I;
         if (st == M || st == O) begin v = 1; op = WB; end
      end else if (wr) begin
         if (st == O) begin
            tag = "R5"; v = 1;
            if (keep) begin nst = O; op = BC; end else begin nst = M; op = INV; end
         end else if ((st == I || st == S) && sh) begin
            tag = "R4"; nst = O; v = 1; op = BC;
         end else begin
            tag = "R3"; nst = M;
            if (st == I) begin v = 1; op = RFO; end
            else if (st == S) begin v = 1; op = INV; end
         end
      end else if (rd && st == I) begin
         nst = sh ? S : E; v = 1; op = RD;
      end
   endfunction

   task automatic step(input logic rd, input logic wr, input logic ev, input logic snv,
         input logic [2:0] sop, input logic sh, input logic keep);
      logic [2:0] nst, op;
      logic v;
      string tag;
      @(negedge clk);
      cpu_rd = rd; cpu_wr = wr; cpu_evict = ev; snoop_valid = snv;
      snoop_op = sop; others_share = sh; own_write_keeps_owned = keep;
      #1;
      check("R11 shared_out", {3'b0, shared_out}, {3'b0, snv && ms != I});
      check("R6/R8 supply_data", {3'b0, supply_data},
            {3'b0, snv && (sop == RD || sop == RFO) && (ms == M || ms == O)});
      model(ms, rd, wr, ev, snv, sop, sh, keep, nst, v, op, tag);
      @(posedge clk);
      #1;
      check({tag, " state"}, {1'b0, line_state}, {1'b0, nst});
      check({"R12 ", tag, " req valid"}, {3'b0, bus_req_valid}, {3'b0, v});
      if (v) check({"R12 ", tag, " req op"}, {1'b0, bus_req_op}, {1'b0, op});
      ms = nst;
   endtask

   initial begin : watchdog
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", {1'b0, line_state}, 4'd0);
      check("R1 reset req", {3'b0, bus_req_valid}, 4'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // directed corners: rd wr ev snv sop sh keep
      step(1,0,0,0,0,0,1);   // R2 I->E
      step(1,0,0,0,0,1,1);   // R2 hit
      step(0,1,0,0,0,1,1);   // R3 E->M silent
      step(0,0,0,1,RD,0,1);  // R6 M->O supply
      step(0,1,0,0,0,1,1);   // R5 stay O
      step(0,1,0,0,0,1,0);   // R5 O->M INV
      step(0,0,1,0,0,0,1);   // R9 WB
      step(0,1,0,0,0,1,1);   // R4 I->O
      step(0,0,0,1,RFO,0,1); // R8 O->S
      step(0,1,0,0,0,0,1);   // R3 S->M INV
      step(0,0,0,1,BC,0,1);  // R7 M->S
      step(0,1,0,1,INV,0,1); // R10 local ignored, R8 S->I
      step(0,1,0,0,0,0,1);   // R3 I->M RFO
      step(0,0,0,1,RFO,0,1); // R8 M->I supply
      step(1,0,0,0,0,1,1);   // R2 I->S
      step(0,0,1,0,0,0,1);   // R9 silent
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] sop;
         sop = 3'($urandom_range(0, 5));
         step(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
              ($urandom % 3) == 0, sop, 1'($urandom), 1'($urandom));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule